// File: doc/BRIEF.md
# SEC-DED Corrector for a 16-bit Memory Word

This block guards a 16-bit memory word with a 6-bit Hsiao code. It corrects any single flipped bit and detects any pair of flipped bits. On the write side it combines the data bits into check bits and returns them in the same cycle, so they can be stored beside the data. In the same cycle it checks the even parity that the system bus sends with each data byte. This check can be turned off.

On the read side it takes a stored word and its check bits. It computes the check bits again from the read data and XORs them with the stored ones to form a syndrome. One clock after a read strobe it registers the syndrome, three error flags and the output data. A mode input chooses between two read paths. In monitor mode the raw data passes through and only the flags are evaluated. In correcting mode a single data-bit error is repaired on the way out.

Each data bit has its own distinct weight-3 column in the generation matrix. A single error therefore gives an odd-weight syndrome, and any two errors give a nonzero even-weight syndrome. Check bits 2 and 3 are stored inverted (odd parity), so an all-zero word with all-zero check bits is never a valid codeword.

Top module: `secded16`

## Requirements
- R1: Each check bit is the XOR of a fixed subset of the data bits. With the inversion of bits 2 and 3 removed, the check bits produced for a word with only data bit i set have exactly three ones, and each of the 16 data bits gives a different pattern. For any words a and b, the check bits of a^b equal the XOR of the check bits of a, of b and of the word 6'b001100.
- R2: Check bits 2 and 3 use odd parity and bits 0, 1, 4 and 5 use even parity, so an all-zero data word gives `wr_chk_o` = 6'b001100 in the same cycle.
- R3: When `par_chk_en_i` is 1, `par_err_o` is 1 in the same cycle if any byte fails even parity: the XOR of `wr_data_i[8b+7:8b]` and `wr_par_i[b]` is 1. Byte 0 is bits 7:0 and byte 1 is bits 15:8. When `par_chk_en_i` is 0, `par_err_o` is 0.
- R4: The first rising clock edge after `rd_valid_i` registers the syndrome, which is the stored check bits XOR the regenerated check bits. A word with the check bits that R1/R2 give for it reads back with a zero syndrome and all three flags low.
- R5: A read with exactly one flipped bit, in the data or in the check field, raises `err_any_o` and `err_single_o` with `err_double_o` low. A flip of stored check bit k alone gives syndrome 1<<k.
- R6: A read with exactly two flipped bits, anywhere in the 22-bit codeword, raises `err_any_o` and `err_double_o` with `err_single_o` low.
- R7: With `mode_i` = 0 (monitor), `rd_data_o` equals the `rd_data_i` of the strobed read, whatever the error status.
- R8: With `mode_i` = 1 (correct), a single data-bit error is repaired on `rd_data_o`. A single check-bit error leaves the data unchanged, and a double error passes the raw read data.
- R9: `rd_valid_o` pulses one cycle after each `rd_valid_i`. Without a strobe, the read-side outputs hold their values.
- R10: While `rst_ni` is low, every registered read-side output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 16 | Data word being written |
| wr_par_i | input | 2 | Even parity bit per byte of the write word |
| par_chk_en_i | input | 1 | Enables the byte parity check |
| wr_chk_o | output | 6 | Check bits to store with the write word |
| par_err_o | output | 1 | Byte parity mismatch on the write word |
| rd_valid_i | input | 1 | Read strobe |
| rd_data_i | input | 16 | Data word read from memory |
| rd_chk_i | input | 6 | Check bits read from memory |
| mode_i | input | 1 | 0 monitor, 1 correct |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 16 | Read data, corrected or raw according to mode |
| syndrome_o | output | 6 | Registered syndrome |
| err_any_o | output | 1 | Nonzero syndrome |
| err_single_o | output | 1 | Correctable single error |
| err_double_o | output | 1 | Uncorrectable double error |

## Verification
The write-side outputs `wr_chk_o` and `par_err_o` are combinational. They are sampled 1 ns after the write inputs settle, within the same cycle. Every read result, meaning the data, syndrome and flags, is due exactly one rising edge after its strobe. The driver presents one read per falling edge and pushes the expected result into a queue. A monitor samples 1 ns after each rising edge and pops one entry for every `rd_valid_o` pulse, so any pulse that is extra, missing or late shows up as a mismatch. Idle cycles after the last read confirm that the outputs hold.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int CHK_MAX = 8;

  // idx-th odd-weight (>=3) column in ascending order of weight, then value
  function automatic logic [CHK_MAX-1:0] hsiao_col(input int idx, input int chk_w);
    int n;
    logic [CHK_MAX-1:0] r;
    n = 0;
    r = '0;
    for (int w = 3; w <= chk_w; w += 2) begin
      for (int v = 0; v < (1 << chk_w); v++) begin
        if ($countones(v) == w && n <= idx) begin
          r = v[CHK_MAX-1:0];
          n++;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 6,
  parameter logic [CHK_W-1:0] INV_MASK = CHK_W'(12)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [CHK_W-1:0] col [DATA_W];

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_col
    localparam logic [secded_pkg::CHK_MAX-1:0] COL = secded_pkg::hsiao_col(gi, CHK_W);
    assign col[gi] = COL[CHK_W-1:0];
  end

  always_comb begin
    chk_o = INV_MASK;
    for (int i = 0; i < DATA_W; i++) chk_o ^= col[i] & {CHK_W{data_i[i]}};
  end
endmodule

// File: rtl/secded_bytepar.sv
module secded_bytepar #(
  parameter int DATA_W = 16,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [NBYTES-1:0] par_i,
  input  logic              en_i,
  output logic              err_o
);
  logic [NBYTES-1:0] bad;

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    assign bad[gb] = ^{data_i[8*gb +: 8], par_i[gb]};
  end

  assign err_o = en_i & |bad;
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 6
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_rd_i,
  input  logic [CHK_W-1:0]  chk_gen_i,
  input  logic              fix_i,
  output logic [CHK_W-1:0]  syn_o,
  output logic [DATA_W-1:0] data_o,
  output logic              any_o,
  output logic              single_o,
  output logic              double_o
);
  logic [CHK_W-1:0]  col [DATA_W];
  logic [DATA_W-1:0] hit;
  logic              chk_hit;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_col
    localparam logic [secded_pkg::CHK_MAX-1:0] COL = secded_pkg::hsiao_col(gi, CHK_W);
    assign col[gi] = COL[CHK_W-1:0];
    assign hit[gi] = (syn_o == col[gi]);
  end

  assign syn_o    = chk_rd_i ^ chk_gen_i;
  assign chk_hit  = (syn_o != '0) && ((syn_o & (syn_o - 1'b1)) == '0);
  assign any_o    = (syn_o != '0);
  assign single_o = (|hit) | chk_hit;
  assign double_o = any_o & ~single_o;
  // check-bit hits never touch data
  assign data_o   = fix_i ? (data_i ^ hit) : data_i;
endmodule

// File: rtl/secded16.sv
module secded16 #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 6,
  parameter logic [CHK_W-1:0] INV_MASK = CHK_W'(12),
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NBYTES-1:0] wr_par_i,
  input  logic              par_chk_en_i,
  output logic [CHK_W-1:0]  wr_chk_o,
  output logic              par_err_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [CHK_W-1:0]  rd_chk_i,
  input  logic              mode_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CHK_W-1:0]  syndrome_o,
  output logic              err_any_o,
  output logic              err_single_o,
  output logic              err_double_o
);
  logic [CHK_W-1:0]  regen;
  logic [CHK_W-1:0]  syn_d;
  logic [DATA_W-1:0] data_d;
  logic              any_d, single_d, double_d;

  secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .INV_MASK(INV_MASK)) u_enc_wr (
    .data_i(wr_data_i), .chk_o(wr_chk_o)
  );

  secded_bytepar #(.DATA_W(DATA_W)) u_par (
    .data_i(wr_data_i), .par_i(wr_par_i), .en_i(par_chk_en_i), .err_o(par_err_o)
  );

  secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .INV_MASK(INV_MASK)) u_enc_rd (
    .data_i(rd_data_i), .chk_o(regen)
  );

  secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
    .data_i(rd_data_i), .chk_rd_i(rd_chk_i), .chk_gen_i(regen), .fix_i(mode_i),
    .syn_o(syn_d), .data_o(data_d), .any_o(any_d), .single_o(single_d),
    .double_o(double_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o   <= 1'b0;
      rd_data_o    <= '0;
      syndrome_o   <= '0;
      err_any_o    <= 1'b0;
      err_single_o <= 1'b0;
      err_double_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_valid_i;
      if (rd_valid_i) begin
        rd_data_o    <= data_d;
        syndrome_o   <= syn_d;
        err_any_o    <= any_d;
        err_single_o <= single_d;
        err_double_o <= double_d;
      end
    end
  end
endmodule

// File: rtl/secded16_chk.sv
module secded16_chk #(
  parameter int DATA_W = 16,
  parameter int CHK_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              par_chk_en_i,
  input logic              par_err_o,
  input logic              rd_valid_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              mode_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CHK_W-1:0]  syndrome_o,
  input logic              err_any_o,
  input logic              err_single_o,
  input logic              err_double_o
);
  AST_PAR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !par_chk_en_i |-> !par_err_o); // R3
  AST_ZERO_SYN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (syndrome_o == '0) |-> !(err_any_o || err_single_o || err_double_o)); // R4
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_single_o && err_double_o)); // R5
  AST_ANY_CLASSIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_any_o |-> (err_single_o || err_double_o)); // R6
  AST_MON_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !mode_i) |=> (rd_data_o == $past(rd_data_i))); // R7
  AST_DOUBLE_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && mode_i) |=> (err_double_o -> (rd_data_o == $past(rd_data_i)))); // R8
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_valid_o); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> (!rd_valid_o && $stable(rd_data_o) && $stable(syndrome_o)
                     && $stable(err_any_o))); // R9
endmodule

bind secded16 secded16_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (.*);

// File: tb/secded16_tb.sv
module secded16_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [1:0]  wr_par_i = '0;
  logic        par_chk_en_i = 1'b0;
  logic [5:0]  wr_chk_o;
  logic        par_err_o;
  logic        rd_valid_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic [5:0]  rd_chk_i = '0;
  logic        mode_i = 1'b0;
  logic        rd_valid_o;
  logic [15:0] rd_data_o;
  logic [5:0]  syndrome_o;
  logic        err_any_o, err_single_o, err_double_o;

  always #2.5 clk_i = ~clk_i;

  secded16 u_dut (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [15:0] data;
    logic        any, single, dbl;
    logic        syn_known;
    logic [5:0]  syn;
    string       req;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input logic [5:0] c, input logic m,
                      input exp_t e);
    @(negedge clk_i);
    rd_valid_i = 1'b1;
    rd_data_i  = d;
    rd_chk_i   = c;
    mode_i     = m;
    q.push_back(e);
  endtask

  // monitor: results due one edge after the strobe
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && rd_valid_o) begin
      if (q.size() == 0) check(1'b0, "R9 extra valid", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(rd_data_o == e.data, {e.req, " data"}, rd_data_o, e.data);
        check({err_any_o, err_single_o, err_double_o} == {e.any, e.single, e.dbl},
              {e.req, " flags"}, {err_any_o, err_single_o, err_double_o},
              {e.any, e.single, e.dbl});
        check((syndrome_o != 0) == e.any, {e.req, " syndrome nonzero"}, syndrome_o,
              e.any);
        if (e.syn_known) check(syndrome_o == e.syn, {e.req, " syndrome"}, syndrome_o, e.syn);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [5:0] enc_probe_unused(input logic [5:0] x);
    return x;
  endfunction

  initial begin
    logic [5:0]  c0, cw, ca, cb, cab;
    logic [5:0]  cols [16];
    logic [15:0] pats [2];
    exp_t        e;

    // R10: reset state
    #7;
    check({rd_valid_o, rd_data_o, syndrome_o, err_any_o, err_single_o, err_double_o} == '0,
          "R10 reset", {rd_valid_o, rd_data_o, syndrome_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: inverted check bits 2 and 3
    wr_data_i = 16'h0000;
    #1;
    c0 = wr_chk_o;
    check(c0 == 6'b001100, "R2 zero word", c0, 6'b001100);

    // R1: weight-3 distinct columns
    for (int i = 0; i < 16; i++) begin
      wr_data_i = 16'(1) << i;
      #1;
      cols[i] = wr_chk_o ^ 6'b001100;
      check($countones(cols[i]) == 3, "R1 column weight", cols[i], 3);
      for (int j = 0; j < i; j++)
        check(cols[i] != cols[j], "R1 distinct columns", cols[i], cols[j]);
    end
    // R1: linearity
    wr_data_i = 16'h3C5A; #1; ca = wr_chk_o;
    wr_data_i = 16'h81F0; #1; cb = wr_chk_o;
    wr_data_i = 16'h3C5A ^ 16'h81F0; #1; cab = wr_chk_o;
    check(cab == (ca ^ cb ^ 6'b001100), "R1 linearity", cab, ca ^ cb ^ 6'b001100);

    // R3: byte parity
    wr_data_i = 16'h0301;
    par_chk_en_i = 1'b1;
    wr_par_i = 2'b01; #1;
    check(par_err_o == 1'b0, "R3 good parity", par_err_o, 0);
    wr_par_i = 2'b00; #1;
    check(par_err_o == 1'b1, "R3 low byte bad", par_err_o, 1);
    wr_par_i = 2'b11; #1;
    check(par_err_o == 1'b1, "R3 high byte bad", par_err_o, 1);
    par_chk_en_i = 1'b0; #1;
    check(par_err_o == 1'b0, "R3 disabled", par_err_o, 0);

    // read sweeps
    pats[0] = 16'h0000;
    pats[1] = 16'hA5C3;
    for (int p = 0; p < 2; p++) begin
      wr_data_i = pats[p];
      #1;
      cw = wr_chk_o;
      for (int m = 0; m < 2; m++) begin
        e = '{data: pats[p], any: 0, single: 0, dbl: 0, syn_known: 1, syn: 0, req: "R4 clean"};
        send(pats[p], cw, m[0], e);
        for (int a = 0; a < 22; a++) begin
          logic [21:0] f;
          f = 22'(1) << a;
          e.any = 1; e.single = 1; e.dbl = 0;
          e.syn_known = (a >= 16);
          e.syn = (a >= 16) ? 6'(1) << (a - 16) : 6'd0;
          e.data = (m == 1) ? pats[p] : pats[p] ^ f[15:0];
          e.req = (m == 1) ? "R8 R5 single" : "R7 R5 single";
          send(pats[p] ^ f[15:0], cw ^ f[21:16], m[0], e);
        end
        for (int a = 0; a < 22; a++) begin
          for (int b = a + 1; b < 22; b++) begin
            logic [21:0] f;
            f = (22'(1) << a) | (22'(1) << b);
            e.any = 1; e.single = 0; e.dbl = 1;
            e.syn_known = 0; e.syn = 0;
            e.data = pats[p] ^ f[15:0];
            e.req = (m == 1) ? "R8 R6 double" : "R7 R6 double";
            send(pats[p] ^ f[15:0], cw ^ f[21:16], m[0], e);
          end
        end
      end
    end
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    rd_data_i = 16'hFFFF;
    rd_chk_i = 6'h3F;
    repeat (2) @(negedge clk_i);

    // R9: outputs hold while no strobe
    begin
      logic [15:0] d_h;
      logic [5:0]  s_h;
      d_h = rd_data_o;
      s_h = syndrome_o;
      repeat (4) @(negedge clk_i);
      check(rd_valid_o == 1'b0, "R9 valid idle", rd_valid_o, 0);
      check(rd_data_o == d_h && syndrome_o == s_h, "R9 hold", {rd_data_o, syndrome_o},
            {d_h, s_h});
    end
    check(q.size() == 0, "R9 missing valid", q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule